// File: doc/BRIEF.md
# Data Memory Access Unit with Atomic Swap

This block sits between a processor pipeline and a data memory. The pipeline presents three inputs: an address, a write-data word and a 32-bit control word. The unit decodes the control word into four parts: a read strobe, a write strobe, an access size and a transfer count. It then performs one of three kinds of operation. The first is a single load or store of a byte, halfword or word. The second is a multi-word burst for load-multiple and store-multiple. The third is an indivisible read-then-write swap of a byte or a word. Read data comes back on a registered read port, marked with a valid strobe.

The control word packs its fields from the least significant bit upward. Bit 0 is the write strobe and bit 1 is the read strobe. Bits 4:2 give the access size in bytes, and bits 31:5 give the word count. Setting both strobes requests a swap. A swap returns the location's previous contents and stores the new data at the same clock edge. A simple flop-based memory array sits behind the unit so that the block can be checked on its own. The unit signals that an operation is in progress, and signals a single-cycle completion pulse.

Top module: `dmem_port`

## Requirements
- R1: Control word decode: bit 0 is write and bit 1 is read. Bits 4:2 are the size in bytes: 1 selects byte, 2 selects halfword, and any other value selects word. Bits 31:5 are the beat count. A count of 0 means one beat, and a count of n means n beats.
- R2: A control word with bits 1:0 both clear is idle. The unit stays not busy, raises neither rvalid_o nor done_o, and writes no memory location.
- R3: A command is accepted at a rising edge where busy_o is low and bits 1:0 are not both clear. Beat k executes at the k-th rising edge after acceptance. A read beat presents its data on rdata_o, with rvalid_o high, in the cycle after that edge. A single word load is control 18 and returns the stored word. rdata_o holds its value between reads.
- R4: A byte load is control 6 and selects the byte lane with addr[1:0]. A halfword load is control 10 and selects the upper half when addr[1] is 1. Results are zero-extended, or sign-extended when sign_ext_i was high at acceptance.
- R5: A byte store is control 5 and a halfword store is control 9. Each writes only the selected lane, using the low bits of wdata_i. A word store is control 17.
- R6: A word swap, control 19, returns the word held before the operation. In the same indivisible beat it replaces that word with wdata_i.
- R7: A byte swap, control 7, returns the old byte of the selected lane, extended as in R4. It replaces only that byte with wdata_i[7:0].
- R8: A load-multiple, control (n<<5)|18, returns n words. The words come from consecutive word addresses starting at the given address, one word per cycle.
- R9: A store-multiple, control (n<<5)|17, writes n words to consecutive word addresses. Beat k stores the wdata_i value that is present during its beat cycle.
- R10: busy_o is high for exactly as many cycles as the command has beats. done_o pulses for one cycle, in the cycle after the last beat edge, while busy_o is low. After reset all outputs are 0.
- R11: Control words presented while busy_o is high are ignored.
- R12: The word index is the address bits above bit 1, taken modulo the array depth. A burst that runs past the top of the array wraps to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_addr_i | input | 32 | Byte address of the first beat |
| req_wdata_i | input | 32 | Write data, sampled on each write beat |
| req_ctrl_i | input | 32 | Packed control word |
| sign_ext_i | input | 1 | Sign-extend sub-word reads, sampled at acceptance |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | rdata_o carries a new read result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench builds the unit with a 64-word array (DEPTH_LOG2 = 6). With that depth, a short store-multiple placed near the top of the address range wraps to word 0. The bench also reads the same word through an aliased address above the array. Together these make the modulo indexing of R12 observable with only a few beats. The count width stays at its full value, so the bench drives real packed control words for bursts, swaps and sub-word accesses.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int CNT_W = 27;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_sz_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [2:0]       size;
    logic             rd;
    logic             wr;
  } ctrl_t;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
(
  input  logic [31:0]      ctrl_i,
  output logic             active_o,
  output logic             rd_o,
  output logic             wr_o,
  output acc_sz_e          sz_o,
  output logic [CNT_W-1:0] beats_o
);
  ctrl_t c;
  assign c        = ctrl_t'(ctrl_i);
  assign rd_o     = c.rd;
  assign wr_o     = c.wr;
  assign active_o = c.rd | c.wr;
  assign beats_o  = (c.count == '0) ? CNT_W'(1) : c.count;

  always_comb begin
    unique case (c.size)
      3'd1:    sz_o = SZ_BYTE;
      3'd2:    sz_o = SZ_HALF;
      default: sz_o = SZ_WORD;
    endcase
  end
endmodule

// File: rtl/dmem_seq.sv
module dmem_seq
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  acc_sz_e           sz_i,
  input  logic              sign_i,
  input  logic [CNT_W-1:0]  beats_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output acc_sz_e           sz_o,
  output logic              sign_o
);
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, wr_q, sign_q;
  acc_sz_e           sz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      sign_q <= 1'b0;
      sz_q   <= SZ_WORD;
    end else if (start_i) begin
      left_q <= beats_i;
      addr_q <= addr_i;
      rd_q   <= rd_i;
      wr_q   <= wr_i;
      sign_q <= sign_i;
      sz_q   <= sz_i;
    end else if (left_q != '0) begin
      left_q <= left_q - CNT_W'(1);
      addr_q <= addr_q + ADDR_W'(4);
    end
  end

  assign busy_o = (left_q != '0);
  assign last_o = (left_q == CNT_W'(1));
  assign addr_o = addr_q;
  assign rd_o   = rd_q;
  assign wr_o   = wr_q;
  assign sz_o   = sz_q;
  assign sign_o = sign_q;
endmodule

// File: rtl/dmem_lane.sv
module dmem_lane
  import dmem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [1:0]        lane_i,
  input  acc_sz_e           sz_i,
  input  logic              sign_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rval_o,
  output logic [DATA_W-1:0] merged_o
);
  localparam int LANES = DATA_W / 8;

  logic [7:0]       sel_b;
  logic [15:0]      sel_h;
  logic [LANES-1:0] be;

  assign sel_b = old_i[8*lane_i +: 8];
  assign sel_h = lane_i[1] ? old_i[31:16] : old_i[15:0];

  always_comb begin
    unique case (sz_i)
      SZ_BYTE: rval_o = {{(DATA_W-8){sign_i & sel_b[7]}}, sel_b};
      SZ_HALF: rval_o = {{(DATA_W-16){sign_i & sel_h[15]}}, sel_h};
      default: rval_o = old_i;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (sz_i)
        SZ_BYTE: be[l] = (lane_i == 2'(l));
        SZ_HALF: be[l] = (lane_i[1] == l[1]);
        default: be[l] = 1'b1;
      endcase
    end
    // sub-word data is replicated across lanes, byte enables pick the target
    logic [7:0] src;
    always_comb begin
      unique case (sz_i)
        SZ_BYTE: src = wdata_i[7:0];
        SZ_HALF: src = wdata_i[8*(l%2) +: 8];
        default: src = wdata_i[8*l +: 8];
      endcase
    end
    assign merged_o[8*l +: 8] = be[l] ? src : old_i[8*l +: 8];
  end
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [DEPTH_LOG2-1:0] idx_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dmem_port.sv
module dmem_port
  import dmem_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [31:0] req_ctrl_i,
  input  logic        sign_ext_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        busy_o,
  output logic        done_o
);
  logic             dec_active, dec_rd, dec_wr;
  acc_sz_e          dec_sz;
  logic [CNT_W-1:0] dec_beats;

  logic        busy, last, b_rd, b_wr, b_sign;
  logic [31:0] b_addr;
  acc_sz_e     b_sz;

  logic [31:0] old_word, rval, merged;
  logic        mem_we;
  logic [31:0] rdata_q;
  logic        rvalid_q, done_q;

  dmem_decode u_dec (
    .ctrl_i  (req_ctrl_i),
    .active_o(dec_active),
    .rd_o    (dec_rd),
    .wr_o    (dec_wr),
    .sz_o    (dec_sz),
    .beats_o (dec_beats)
  );

  dmem_seq #(.ADDR_W(32)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(dec_active & ~busy),
    .addr_i (req_addr_i),
    .rd_i   (dec_rd),
    .wr_i   (dec_wr),
    .sz_i   (dec_sz),
    .sign_i (sign_ext_i),
    .beats_i(dec_beats),
    .busy_o (busy),
    .last_o (last),
    .addr_o (b_addr),
    .rd_o   (b_rd),
    .wr_o   (b_wr),
    .sz_o   (b_sz),
    .sign_o (b_sign)
  );

  dmem_lane #(.DATA_W(32)) u_lane (
    .old_i   (old_word),
    .lane_i  (b_addr[1:0]),
    .sz_i    (b_sz),
    .sign_i  (b_sign),
    .wdata_i (req_wdata_i),
    .rval_o  (rval),
    .merged_o(merged)
  );

  assign mem_we = busy & b_wr;

  dmem_array #(.DATA_W(32), .DEPTH_LOG2(DEPTH_LOG2)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .idx_i  (b_addr[DEPTH_LOG2+1:2]),
    .wdata_i(merged),
    .rdata_o(old_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      rvalid_q <= busy & b_rd;
      done_q   <= busy & last;
      if (busy & b_rd) rdata_q <= rval;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign busy_o   = busy;
  assign done_o   = done_q;
endmodule

// File: rtl/dmem_port_chk.sv
module dmem_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] ctrl_i,
  input logic        busy_i,
  input logic        rvalid_i,
  input logic        done_i,
  input logic        mem_we_i
);
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && ctrl_i[1:0] != 2'b00) |=> busy_i); // R1
  AST_IDLE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && ctrl_i[1:0] == 2'b00) |=> !busy_i); // R2
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_we_i); // R2
  AST_RVALID_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> $past(busy_i)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(busy_i) && !busy_i)); // R10
  AST_FALL_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R10
endmodule

bind dmem_port dmem_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_i  (req_ctrl_i),
  .busy_i  (busy_o),
  .rvalid_i(rvalid_o),
  .done_i  (done_o),
  .mem_we_i(mem_we)
);

// File: tb/sim_dmem_port.sv
`timescale 1ns/1ps
module sim_dmem_port;
  localparam int DL    = 6;
  localparam int DEPTH = 1 << DL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0, ctrl_i = '0;
  logic        sign_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rvalid_o, busy_o, done_o;

  int total = 0, fails = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  dmem_port #(.DEPTH_LOG2(DL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_addr_i(addr_i), .req_wdata_i(wdata_i),
    .req_ctrl_i(ctrl_i), .sign_ext_i(sign_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mm [DEPTH];
  int          m_left = 0;
  logic [31:0] m_addr;
  bit          m_rd, m_wr, m_sign;
  int          m_bytes;
  logic [31:0] e_rdata = '0;
  bit          e_rvalid = 0, e_done = 0, e_busy = 0;

  function automatic logic [31:0] m_ext(logic [31:0] w, logic [1:0] a, int nb, bit s);
    logic [31:0] v;
    if (nb == 1) begin v = (w >> (8 * a)) & 32'hFF; if (s && v[7]) v |= 32'hFFFFFF00; end
    else if (nb == 2) begin v = (w >> (a[1] ? 16 : 0)) & 32'hFFFF; if (s && v[15]) v |= 32'hFFFF0000; end
    else v = w;
    return v;
  endfunction

  function automatic logic [31:0] m_put(logic [31:0] w, logic [1:0] a, int nb, logic [31:0] d);
    logic [31:0] msk;
    int sh;
    if (nb == 1) begin sh = 8 * a; msk = 32'hFF << sh; end
    else if (nb == 2) begin sh = a[1] ? 16 : 0; msk = 32'hFFFF << sh; end
    else begin sh = 0; msk = 32'hFFFFFFFF; end
    return (w & ~msk) | ((d << sh) & msk);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      m_left = 0; e_rdata = '0; e_rvalid = 0; e_done = 0; e_busy = 0;
    end else begin
      e_rvalid = 0; e_done = 0;
      if (m_left > 0) begin
        int idx;
        idx = (m_addr >> 2) % DEPTH;
        if (m_rd) begin e_rdata = m_ext(mm[idx], m_addr[1:0], m_bytes, m_sign); e_rvalid = 1; end
        if (m_wr) mm[idx] = m_put(mm[idx], m_addr[1:0], m_bytes, wdata_i);
        m_addr += 4;
        m_left--;
        if (m_left == 0) e_done = 1;
      end else if (ctrl_i[1:0] != 2'b00) begin
        m_left  = (ctrl_i[31:5] == 0) ? 1 : int'(ctrl_i[31:5]);
        m_addr  = addr_i;
        m_rd    = ctrl_i[1];
        m_wr    = ctrl_i[0];
        m_sign  = sign_i;
        m_bytes = (ctrl_i[4:2] == 3'd1) ? 1 : (ctrl_i[4:2] == 3'd2) ? 2 : 4;
      end
      e_busy = (m_left > 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " busy"}, {31'b0, busy_o}, {31'b0, e_busy});
      chk({cur_req, " rvalid"}, {31'b0, rvalid_o}, {31'b0, e_rvalid});
      chk({cur_req, " done"}, {31'b0, done_o}, {31'b0, e_done});
      chk({cur_req, " rdata"}, rdata_o, e_rdata);
    end
  end

  logic [31:0] rq [$];

  // called at a negedge; returns at the negedge where done_o is seen
  task automatic run(input logic [31:0] ctrl, input logic [31:0] addr, input logic [31:0] wd,
                     input bit sgn, input bit burst, input bit inject, output int busy_n);
    int k = 0;
    busy_n = 0;
    rq.delete();
    ctrl_i = ctrl; addr_i = addr; wdata_i = wd; sign_i = sgn;
    @(negedge clk);
    if (inject) begin ctrl_i = 32'h0000_0011; addr_i = 32'h80; end
    else ctrl_i = '0;
    while (!done_o) begin
      if (busy_o) begin
        busy_n++;
        if (burst) begin wdata_i = 32'hA000_0000 + k; k++; end
      end
      @(negedge clk);
      if (inject) begin ctrl_i = '0; inject = 0; end
      if (rvalid_o) rq.push_back(rdata_o);
    end
    ctrl_i = '0;
  endtask

  task automatic rd_word(input logic [31:0] addr, output logic [31:0] v);
    int n;
    run(32'd18, addr, '0, 0, 0, 0, n);
    v = (rq.size() > 0) ? rq[$] : 32'hXXXX_XXXX;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R10 watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", {31'b0, busy_o}, 32'd0);
    chk("R10 reset rvalid", {31'b0, rvalid_o}, 32'd0);
    chk("R10 reset rdata", rdata_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 idle words: no strobe bits, other fields set
    cur_req = "R2";
    ctrl_i = 32'h0000_007C; addr_i = 32'h30; wdata_i = 32'hFFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      chk("R2 idle busy", {31'b0, busy_o}, 32'd0);
    end
    ctrl_i = '0;
    rd_word(32'h30, v);
    chk("R2 idle wrote nothing", v, 32'h0);

    // R3 word store/load, R10 single-beat busy length
    cur_req = "R3";
    run(32'd17, 32'h10, 32'hCAFE_F00D, 0, 0, 0, n);
    chk("R10 single beat busy cycles", n, 1);
    rd_word(32'h10, v);
    chk("R3 word load", v, 32'hCAFE_F00D);

    // R5 sub-word stores, R4 sub-word loads
    cur_req = "R5";
    run(32'd5, 32'h21, 32'h1234_5680, 0, 0, 0, n);
    rd_word(32'h20, v);
    chk("R5 byte store lane 1", v, 32'h0000_8000);
    cur_req = "R4";
    run(32'd6, 32'h21, '0, 1, 0, 0, n);
    chk("R4 byte load signed", rq[$], 32'hFFFF_FF80);
    run(32'd6, 32'h21, '0, 0, 0, 0, n);
    chk("R4 byte load zero-ext", rq[$], 32'h0000_0080);
    cur_req = "R5";
    run(32'd9, 32'h22, 32'h1234_BEEF, 0, 0, 0, n);
    rd_word(32'h20, v);
    chk("R5 half store upper", v, 32'hBEEF_8000);
    cur_req = "R4";
    run(32'd10, 32'h22, '0, 1, 0, 0, n);
    chk("R4 half load signed upper", rq[$], 32'hFFFF_BEEF);
    run(32'd10, 32'h20, '0, 0, 0, 0, n);
    chk("R4 half load lower zero-ext", rq[$], 32'h0000_8000);

    // R6 word swap
    cur_req = "R6";
    run(32'd19, 32'h10, 32'h1234_5678, 0, 0, 0, n);
    chk("R6 swap returns old word", rq[$], 32'hCAFE_F00D);
    chk("R6 swap single beat", n, 1);
    rd_word(32'h10, v);
    chk("R6 swap stored new word", v, 32'h1234_5678);

    // R7 byte swap on lane 3
    cur_req = "R7";
    run(32'd7, 32'h23, 32'hFFFF_FF55, 0, 0, 0, n);
    chk("R7 byte swap old byte", rq[$], 32'h0000_00BE);
    rd_word(32'h20, v);
    chk("R7 byte swap replaced one lane", v, 32'h55EF_8000);

    // R9 store-multiple with ignored control word mid-burst (R11)
    cur_req = "R9";
    run((32'd4 << 5) | 32'd17, 32'h40, 32'h0, 0, 1, 1, n);
    chk("R10 burst busy cycles", n, 4);
    rd_word(32'h80, v);
    chk("R11 control while busy ignored", v, 32'h0);
    rd_word(32'h4C, v);
    chk("R9 last burst word", v, 32'hA000_0003);

    // R8 load-multiple
    cur_req = "R8";
    run((32'd4 << 5) | 32'd18, 32'h40, '0, 0, 0, 0, n);
    chk("R8 beat count", rq.size(), 4);
    for (int i = 0; i < 4; i++)
      chk("R8 burst word", (i < rq.size()) ? rq[i] : 32'hX, 32'hA000_0000 + i);

    // R1 decode: count field 3 with read strobe only
    cur_req = "R1";
    run((32'd3 << 5) | 32'd18, 32'h40, '0, 0, 0, 0, n);
    chk("R1 count field beats", n, 3);

    // R12 wrap past top of 64-word array
    cur_req = "R12";
    run((32'd3 << 5) | 32'd17, 32'hF8, '0, 0, 1, 0, n);
    rd_word(32'h0, v);
    chk("R12 wrapped to word 0", v, 32'hA000_0002);
    rd_word(32'h100, v);
    chk("R12 alias above array", v, 32'hA000_0002);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule